// File: doc/BRIEF.md
# ADC Sample Queue with Rotation Marker

This block buffers converter results between a sampling engine and a host that reads through byte-wide registers. Each accepted 14-bit sample is scaled by four and stored as a 16-bit word. The two bits freed at the bottom of the word carry a marker: bit 0 flips from one entry to the next. It holds its previous value on the entry that opens a new channel rotation. A host can therefore find the first channel in the stream without extra sideband data.

The host reads the head word as two bytes. The low byte can be read any number of times. Reading the high byte consumes the entry. Reading an empty queue yields zero and is not an error. The block also provides the following:
- a fill level;
- an almost-full indication against a programmable threshold;
- a sticky overflow flag;
- a one-cycle flush.

Top module: `sample_fifo`

## Requirements
- R1: An accepted sample `s` is stored as `{s, 1'b0, m}`: the sample sits in bits 15:2, bit 1 is 0 and bit 0 is the marker `m`.
- R2: The marker starts at 0 after reset. For an entry pushed with `wr_first`=0, bit 0 is the inverse of the previous pushed entry's bit 0. For an entry pushed with `wr_first`=1, bit 0 equals the previous pushed entry's bit 0.
- R3: With `rd_lo`=1, `rd_data` shows bits 7:0 of the head entry and nothing changes. With `rd_hi`=1, `rd_data` shows bits 15:8, and at the next edge the entry is removed and `level` drops by one.
- R4: A read while the queue is empty shows `rd_data`=0x00, and `level` stays 0 with no other flag raised.
- R5: After reset, `level` is 0 and `overflow` is 0. `level` spans 0 to 64.
- R6: `above_thr` is 1 exactly when `level` is greater than the threshold. The threshold resets to 19 and is loaded from `thr_data` when `thr_wr`=1. A threshold of 63 asserts only at 64 entries.
- R7: A push while 64 entries are held, with no pop in the same cycle, is discarded and sets `overflow`. `overflow` stays set until `ovf_clr` is pulsed.
- R8: A `clear` pulse empties the queue by the next edge, overrides a push or pop in the same cycle, and returns the marker to 0.
- R9: A push and a pop in the same cycle leave `level` unchanged, including when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Sample strobe |
| wr_sample | input | 14 | Converter result |
| wr_first | input | 1 | Sample opens a new channel rotation |
| clear | input | 1 | Flush all entries and reset marker |
| rd_lo | input | 1 | Low-byte read, no side effect |
| rd_hi | input | 1 | High-byte read, pops the head entry |
| rd_data | output | 8 | Byte selected by the current read, 0 when empty or idle |
| thr_wr | input | 1 | Load threshold |
| thr_data | input | 6 | New threshold value |
| ovf_clr | input | 1 | Clear the overflow flag |
| level | output | 7 | Number of stored entries |
| overflow | output | 1 | Sticky lost-sample flag |
| above_thr | output | 1 | Level greater than threshold |

## Verification
A corrupted marker register shows up on the next entry that is pushed and read back. The wrong bit 0 then appears in the low byte at the host, one entry later than the fault. A read pointer that slips or a level counter that drifts shows up at the ports in two ways. The next high-byte read returns a byte from the wrong entry, or `level` and `above_thr` disagree with the count of pushes and pops one cycle after the edge. A lost sticky overflow shows up on the first cycle `overflow` falls without an `ovf_clr` pulse.

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DEPTH    = 64,
  parameter int SMP_W    = 14,
  parameter int THR_W    = 6,
  parameter int THR_INIT = 19
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [SMP_W-1:0]             wr_sample,
  input  logic                         wr_first,
  input  logic                         clear,
  input  logic                         rd_lo,
  input  logic                         rd_hi,
  output logic [7:0]                   rd_data,
  input  logic                         thr_wr,
  input  logic [THR_W-1:0]             thr_data,
  input  logic                         ovf_clr,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         overflow,
  output logic                         above_thr
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH+1);
  localparam int WORD  = SMP_W + 2;

  logic [WORD-1:0] mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [THR_W-1:0] thr;
  logic            mark;
  logic            empty, full, pop, push, mark_nxt;
  logic [WORD-1:0] head;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign pop      = rd_hi && !empty && !clear;
  assign push     = wr_valid && !clear && (!full || pop);
  assign mark_nxt = wr_first ? mark : ~mark;
  assign head     = mem[rp];
  assign rd_data  = (empty || !(rd_lo || rd_hi)) ? 8'h00 :
                    rd_hi ? head[15:8] : head[7:0];
  assign above_thr = level > LW'(thr);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_sample, 1'b0, mark_nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0; mark <= 1'b0;
    end else if (clear) begin
      wp <= '0; rp <= '0; level <= '0; mark <= 1'b0;
    end else begin
      if (push) begin
        wp   <= wp + AW'(1);
        mark <= mark_nxt;
      end
      if (pop) rp <= rp + AW'(1);
      if (push && !pop)      level <= level + LW'(1);
      else if (pop && !push) level <= level - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= THR_W'(THR_INIT);
      overflow <= 1'b0;
    end else begin
      if (thr_wr) thr <= thr_data;
      if (wr_valid && !clear && full && !pop) overflow <= 1'b1;
      else if (ovf_clr)                       overflow <= 1'b0;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (level == '0) && !above_thr); // R8
  AST_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !empty && !wr_valid && !clear) |=> level == $past(level) - LW'(1)); // R3
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !empty && wr_valid && !clear) |=> level == $past(level)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (rd_data == 8'h00)); // R4
endmodule

// File: tb/sample_fifo_bench.sv
`timescale 1ns/1ps
module sample_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_first = 0, clear = 0, rd_lo = 0, rd_hi = 0;
  logic thr_wr = 0, ovf_clr = 0;
  logic [13:0] wr_sample = '0;
  logic [5:0]  thr_data = '0;
  logic [7:0]  rd_data;
  logic [6:0]  level;
  logic        overflow, above_thr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sample_fifo u_sample_fifo (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_sample(wr_sample), .wr_first(wr_first), .clear(clear), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .rd_data(rd_data), .thr_wr(thr_wr), .thr_data(thr_data),
    .ovf_clr(ovf_clr), .level(level), .overflow(overflow), .above_thr(above_thr));

  // {sample, first, expected low byte, expected high byte}
  localparam logic [30:0] TBL [8] = '{
    {14'h0001, 1'b1, 8'h04, 8'h00},
    {14'h3FFF, 1'b0, 8'hFD, 8'hFF},
    {14'h1234, 1'b0, 8'hD0, 8'h48},
    {14'h0ABC, 1'b1, 8'hF0, 8'h2A},
    {14'h2000, 1'b0, 8'h01, 8'h80},
    {14'h0155, 1'b0, 8'h54, 8'h05},
    {14'h3001, 1'b1, 8'h04, 8'hC0},
    {14'h0002, 1'b1, 8'h08, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [13:0] s, input logic f);
    wr_valid = 1; wr_sample = s; wr_first = f;
    @(posedge clk); #1 wr_valid = 0; wr_first = 0;
  endtask

  task automatic rd(input logic hi, output logic [7:0] d);
    if (hi) rd_hi = 1; else rd_lo = 1;
    #1 d = rd_data;
    @(posedge clk); #1 rd_hi = 0; rd_lo = 0;
  endtask

  task automatic pulse_clear();
    clear = 1; @(posedge clk); #1 clear = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #7 rst_n = 1;
    @(posedge clk); #1;
    chk("R5 reset level", level, 0);
    chk("R5 reset overflow", overflow, 0);
    chk("R6 reset above_thr", above_thr, 0);
    rd(1'b1, d);
    chk("R4 empty read data", d, 0);
    chk("R4 empty read level", level, 0);
    chk("R4 empty read overflow", overflow, 0);

    for (int i = 0; i < 8; i++) push(TBL[i][30:17], TBL[i][16]);
    chk("R5 level after 8", level, 8);
    for (int i = 0; i < 8; i++) begin
      rd(1'b0, d); chk("R1 R2 low byte", d, TBL[i][15:8]);
      rd(1'b0, d); chk("R3 low read repeat", d, TBL[i][15:8]);
      chk("R3 low read keeps level", level, 8 - i);
      rd(1'b1, d); chk("R1 high byte", d, TBL[i][7:0]);
      chk("R3 high read pops", level, 7 - i);
    end

    for (int i = 0; i < 19; i++) push(14'(i), 1'b0);
    chk("R6 at threshold", above_thr, 0);
    push(14'h0100, 1'b0);
    chk("R6 above threshold", above_thr, 1);
    for (int i = 20; i < 64; i++) push(14'(i), 1'b0);
    chk("R5 full level", level, 64);
    chk("R7 no overflow yet", overflow, 0);
    push(14'h1111, 1'b0);
    chk("R7 dropped level", level, 64);
    chk("R7 overflow set", overflow, 1);
    rd(1'b1, d);
    chk("R7 head kept", d, 8'h00);
    chk("R7 sticky after pop", overflow, 1);
    ovf_clr = 1; @(posedge clk); #1 ovf_clr = 0;
    chk("R7 overflow cleared", overflow, 0);

    thr_wr = 1; thr_data = 6'd63; @(posedge clk); #1 thr_wr = 0;
    chk("R6 thr63 at 63", above_thr, 0);
    push(14'h0001, 1'b0);
    chk("R6 thr63 at 64", above_thr, 1);
    wr_valid = 1; wr_sample = 14'h0222; rd_hi = 1;
    @(posedge clk); #1 wr_valid = 0; rd_hi = 0;
    chk("R9 push+pop full level", level, 64);
    chk("R9 push+pop no overflow", overflow, 0);

    wr_valid = 1; wr_sample = 14'h0333; clear = 1;
    @(posedge clk); #1 wr_valid = 0; clear = 0;
    chk("R8 clear level", level, 0);
    chk("R8 clear above_thr", above_thr, 0);
    push(14'h0000, 1'b0);
    pulse_clear();
    push(14'h0000, 1'b0);
    rd(1'b0, d);
    chk("R8 marker reset", d, 8'h01);
    push(14'h0000, 1'b1);
    rd(1'b1, d); rd(1'b0, d);
    chk("R2 first holds marker", d, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule